// File: doc/BRIEF.md
# Tick-Based Static Error Calculator

This block turns a table of measured tick counts, one per output-code transition of a converter under test, into static linearity figures. A ramp-based measurement elsewhere fills a memory with the number of clock ticks the ramp spent on each code. Given the ideal number of ticks per LSB, the block walks that memory from the lowest code upward. For every code it emits the differential nonlinearity (DNL) and the running integral nonlinearity (INL).

After the last code it divides the full-scale tick deviation by the ideal count to form the full-scale error. It then derives the gain error from the full-scale error and the offset error. All results are signed fixed-point values in LSB with `FRAC` fractional bits; with the default of 8, one unit is 1/256 LSB. Every quotient is formed by one shared sequential restoring divider, and the sign is applied afterwards.

The block reads one word per code through a synchronous memory port with a one-cycle read latency. It produces a strobed result stream while it runs and three held result registers when it finishes. An ideal tick count of zero cannot be divided by, so the block refuses such a run.

Top module: `tse_calc`

## Requirements
- R1: For code i with measured ticks p and ideal ticks t, `res_dnl` equals ((p − t)·2^FRAC)/t truncated toward zero, as a two's-complement value in units of 2^−FRAC LSB. With t = 20 and p = 21 it is 12, which is the 0.05 LSB step.
- R2: `res_inl` for code 0 equals its DNL. For every later code it equals the previous code's `res_inl` plus the current `res_dnl`.
- R3: Codes 0 through 2^CODE_BITS − 2 are processed in ascending order. `rd_addr` gives the code being fetched, and exactly one single-cycle `res_valid` strobe per code carries that code on `res_code`.
- R4: `offset_err` equals the DNL of code 0.
- R5: `fs_err` equals ((F − t·2^CODE_BITS)·2^FRAC)/t truncated toward zero, where F is `fs_ticks`.
- R6: `gain_err` equals `fs_err` minus `offset_err`.
- R7: `done` is a single-cycle pulse that follows the last `res_valid` strobe. When it is high, `offset_err`, `fs_err` and `gain_err` hold the results of the run, and they keep them until the next accepted start.
- R8: A start with `ideal_ticks` = 0 sets `err_zero`. Such a run issues no read, no result strobe and no `done`. `err_zero` stays set until the next accepted start, which clears it.
- R9: After reset, `res_valid`, `done`, `err_zero`, `rd_en` and all result outputs are zero.
- R10: While a run is in progress, `start` and changes on `ideal_ticks` and `fs_ticks` have no effect on that run's results. Both inputs are captured only when the start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when the block is idle |
| ideal_ticks | input | TICK_W | Ideal ticks per LSB, captured at start |
| fs_ticks | input | FS_W | Measured ticks for the full-scale sweep, captured at start |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | CODE_BITS | Code whose tick count is read |
| rd_data | input | TICK_W | Tick count, valid the cycle after `rd_en` |
| res_valid | output | 1 | Per-code result strobe |
| res_code | output | CODE_BITS | Code of the current result |
| res_dnl | output | RES_W | Signed DNL, FRAC fractional bits |
| res_inl | output | RES_W | Signed INL, FRAC fractional bits |
| done | output | 1 | Run finished pulse |
| err_zero | output | 1 | Run refused because the ideal count was zero |
| offset_err | output | RES_W | Signed offset error |
| fs_err | output | RES_W | Signed full-scale error |
| gain_err | output | RES_W | Signed gain error |

## Verification
The result for the last code and the start of the full-scale division happen in the same cycle. In that cycle the sequencer switches the divider's dividend over to the full-scale difference while the accumulator is still registering the last DNL and INL. A second overlap is the capture of the offset, which shares its cycle with the first result strobe. The gain subtraction later depends on that captured offset.

Every table vector runs through both overlaps. The vectors use steady, alternating, missing-code and saturated tick patterns, and both signs of full-scale deviation. Each vector is judged on the last code's pair and on `fs_err` and `gain_err`, all compared with values the bench computes by plain integer arithmetic. One vector also pulses `start` with a different ideal count partway through the run; its results must not change.

// File: rtl/tse_pkg.sv
package tse_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_LOAD,
    ST_DIV,
    ST_FS
  } tse_state_e;

endpackage

// File: rtl/tse_divider.sv
module tse_divider #(
  parameter int N_W = 24,
  parameter int D_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic           done,
  output logic [N_W-1:0] quotient
);

  localparam int CNT_W = $clog2(N_W + 1);
  localparam int PW    = N_W + D_W;

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [D_W-1:0]   rem;
  logic [N_W-1:0]   quo;
  logic [N_W-1:0]   dvd_q;
  logic [D_W-1:0]   dsr_q;

  // one restoring step: shift in the next dividend bit, try to subtract
  logic [D_W:0] shifted;
  logic         fits;
  logic [D_W:0] rem_nxt;

  assign shifted  = {rem, quo[N_W-1]};
  assign fits     = shifted >= {1'b0, dsr_q};
  assign rem_nxt  = fits ? (shifted - {1'b0, dsr_q}) : shifted;
  assign quotient = quo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      rem   <= '0;
      quo   <= '0;
      dvd_q <= '0;
      dsr_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        cnt   <= CNT_W'(N_W);
        rem   <= '0;
        quo   <= dividend;
        dvd_q <= dividend;
        dsr_q <= divisor;
      end else if (busy) begin
        rem <= rem_nxt[D_W-1:0];
        quo <= {quo[N_W-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // the partial remainder always stays below the divisor
  assert_rem_fits_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rem_nxt[D_W] == 1'b0);

  // quotient times divisor plus remainder rebuilds the dividend
  assert_div_identity_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (PW'(quo) * PW'(dsr_q) + PW'(rem)) == PW'(dvd_q) && rem < dsr_q);

endmodule

// File: rtl/tse_seq.sv
module tse_seq import tse_pkg::*; #(
  parameter int CODE_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 ideal_zero,
  input  logic                 div_done,
  output logic                 load_cfg,
  output logic                 reject,
  output logic                 rd_en,
  output logic [CODE_BITS-1:0] rd_addr,
  output logic                 div_start,
  output logic                 div_sel_fs,
  output logic                 emit,
  output logic                 emit_first,
  output logic [CODE_BITS-1:0] emit_code,
  output logic                 finish
);

  localparam int LAST_CODE = 2 ** CODE_BITS - 2;

  tse_state_e           state, state_nxt;
  logic [CODE_BITS-1:0] code;
  logic                 last_code;

  assign last_code  = code == CODE_BITS'(LAST_CODE);
  assign rd_addr    = code;
  assign emit_code  = code;
  assign emit_first = code == '0;

  always_comb begin
    state_nxt  = state;
    load_cfg   = 1'b0;
    reject     = 1'b0;
    rd_en      = 1'b0;
    div_start  = 1'b0;
    div_sel_fs = 1'b0;
    emit       = 1'b0;
    finish     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start && ideal_zero) begin
          reject = 1'b1;
        end else if (start) begin
          load_cfg  = 1'b1;
          state_nxt = ST_READ;
        end
      end
      ST_READ: begin
        rd_en     = 1'b1;
        state_nxt = ST_LOAD;
      end
      ST_LOAD: begin
        div_start = 1'b1;
        state_nxt = ST_DIV;
      end
      ST_DIV: begin
        if (div_done) begin
          emit = 1'b1;
          if (last_code) begin
            // last result and the full-scale division share this cycle
            div_start  = 1'b1;
            div_sel_fs = 1'b1;
            state_nxt  = ST_FS;
          end else begin
            state_nxt = ST_READ;
          end
        end
      end
      ST_FS: begin
        if (div_done) begin
          finish    = 1'b1;
          state_nxt = ST_IDLE;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      code  <= '0;
    end else begin
      state <= state_nxt;
      if (load_cfg) begin
        code <= '0;
      end else if (emit && !last_code) begin
        code <= code + 1'b1;
      end
    end
  end

  // a start is taken only when idle
  assert_start_idle_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (load_cfg || reject) |-> state == ST_IDLE);

  // reads never run past the last transition code
  assert_addr_range_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_addr <= CODE_BITS'(LAST_CODE));

endmodule

// File: rtl/tse_accum.sv
module tse_accum #(
  parameter int CODE_BITS = 4,
  parameter int RES_W     = 26
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    emit,
  input  logic                    emit_first,
  input  logic [CODE_BITS-1:0]    emit_code,
  input  logic                    finish,
  input  logic signed [RES_W-1:0] quot,
  output logic                    res_valid,
  output logic [CODE_BITS-1:0]    res_code,
  output logic signed [RES_W-1:0] res_dnl,
  output logic signed [RES_W-1:0] res_inl,
  output logic signed [RES_W-1:0] offset_err,
  output logic signed [RES_W-1:0] fs_err,
  output logic signed [RES_W-1:0] gain_err,
  output logic                    done
);

  logic signed [RES_W-1:0] inl_acc;
  logic signed [RES_W-1:0] inl_nxt;

  assign inl_nxt = emit_first ? quot : inl_acc + quot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_code   <= '0;
      res_dnl    <= '0;
      res_inl    <= '0;
      inl_acc    <= '0;
      offset_err <= '0;
      fs_err     <= '0;
      gain_err   <= '0;
      done       <= 1'b0;
    end else begin
      res_valid <= emit;
      done      <= finish;
      if (clear) begin
        inl_acc    <= '0;
        offset_err <= '0;
        fs_err     <= '0;
        gain_err   <= '0;
      end
      if (emit) begin
        res_code <= emit_code;
        res_dnl  <= quot;
        res_inl  <= inl_nxt;
        inl_acc  <= inl_nxt;
        if (emit_first) offset_err <= quot;
      end
      if (finish) begin
        fs_err   <= quot;
        gain_err <= quot - offset_err;
      end
    end
  end

  // observation state for the checks below
  logic                    seen;
  logic signed [RES_W-1:0] prev_inl;
  logic [CODE_BITS-1:0]    prev_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      prev_inl  <= '0;
      prev_code <= '0;
    end else if (clear) begin
      seen <= 1'b0;
    end else if (res_valid) begin
      seen      <= 1'b1;
      prev_inl  <= res_inl;
      prev_code <= res_code;
    end
  end

  assert_inl_first_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !seen) |-> res_inl == res_dnl);

  assert_inl_running_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && seen) |-> res_inl == prev_inl + res_dnl);

  assert_code_order_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && seen) |-> res_code == prev_code + 1'b1);

  assert_offset_first_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == '0) |-> offset_err == res_dnl);

  assert_gain_diff_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    done |-> gain_err == fs_err - offset_err);

  assert_done_pulse_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !res_valid);

endmodule

// File: rtl/tse_calc.sv
module tse_calc #(
  parameter int CODE_BITS = 4,
  parameter int TICK_W    = 12,
  parameter int FRAC      = 8,
  parameter int FS_W      = TICK_W + CODE_BITS,
  parameter int RES_W     = FS_W + FRAC + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [TICK_W-1:0]       ideal_ticks,
  input  logic [FS_W-1:0]         fs_ticks,
  output logic                    rd_en,
  output logic [CODE_BITS-1:0]    rd_addr,
  input  logic [TICK_W-1:0]       rd_data,
  output logic                    res_valid,
  output logic [CODE_BITS-1:0]    res_code,
  output logic signed [RES_W-1:0] res_dnl,
  output logic signed [RES_W-1:0] res_inl,
  output logic                    done,
  output logic                    err_zero,
  output logic signed [RES_W-1:0] offset_err,
  output logic signed [RES_W-1:0] fs_err,
  output logic signed [RES_W-1:0] gain_err
);

  localparam int MAG_W  = FS_W + FRAC;
  localparam int DIFF_W = FS_W + 2;

  // magnitude of a tick difference, scaled to the fixed-point grid
  function automatic logic [MAG_W-1:0] scaled_mag(input logic signed [DIFF_W-1:0] d);
    logic [DIFF_W-1:0] m;
    m = d[DIFF_W-1] ? -d : d;
    return {m[FS_W-1:0], {FRAC{1'b0}}};
  endfunction

  // unsigned quotient back to a signed result (truncation toward zero)
  function automatic logic signed [RES_W-1:0] apply_sign(input logic [MAG_W-1:0] q,
                                                         input logic neg);
    logic signed [RES_W-1:0] s;
    s = $signed({2'b00, q});
    return neg ? -s : s;
  endfunction

  logic                    load_cfg, reject;
  logic                    div_start, div_sel_fs, div_done;
  logic                    emit, emit_first, finish;
  logic [CODE_BITS-1:0]    emit_code;
  logic [TICK_W-1:0]       ideal_q;
  logic [FS_W-1:0]         fs_q;
  logic                    neg_q;
  logic [MAG_W-1:0]        quo;
  logic signed [DIFF_W-1:0] code_diff, fs_diff, sel_diff;
  logic [MAG_W-1:0]        div_dividend;
  logic signed [RES_W-1:0] quot_signed;

  assign code_diff = $signed({{(DIFF_W-TICK_W){1'b0}}, rd_data})
                   - $signed({{(DIFF_W-TICK_W){1'b0}}, ideal_q});
  assign fs_diff   = $signed({2'b00, fs_q})
                   - $signed({2'b00, ideal_q, {CODE_BITS{1'b0}}});
  assign sel_diff     = div_sel_fs ? fs_diff : code_diff;
  assign div_dividend = scaled_mag(sel_diff);
  assign quot_signed  = apply_sign(quo, neg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ideal_q  <= '0;
      fs_q     <= '0;
      neg_q    <= 1'b0;
      err_zero <= 1'b0;
    end else begin
      if (load_cfg) begin
        ideal_q  <= ideal_ticks;
        fs_q     <= fs_ticks;
        err_zero <= 1'b0;
      end
      if (reject) err_zero <= 1'b1;
      if (div_start) neg_q <= sel_diff[DIFF_W-1];
    end
  end

  tse_seq #(
    .CODE_BITS (CODE_BITS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ideal_zero (ideal_ticks == '0),
    .div_done   (div_done),
    .load_cfg   (load_cfg),
    .reject     (reject),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .div_start  (div_start),
    .div_sel_fs (div_sel_fs),
    .emit       (emit),
    .emit_first (emit_first),
    .emit_code  (emit_code),
    .finish     (finish)
  );

  tse_divider #(
    .N_W (MAG_W),
    .D_W (TICK_W)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (div_dividend),
    .divisor  (ideal_q),
    .done     (div_done),
    .quotient (quo)
  );

  tse_accum #(
    .CODE_BITS (CODE_BITS),
    .RES_W     (RES_W)
  ) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (load_cfg),
    .emit       (emit),
    .emit_first (emit_first),
    .emit_code  (emit_code),
    .finish     (finish),
    .quot       (quot_signed),
    .res_valid  (res_valid),
    .res_code   (res_code),
    .res_dnl    (res_dnl),
    .res_inl    (res_inl),
    .offset_err (offset_err),
    .fs_err     (fs_err),
    .gain_err   (gain_err),
    .done       (done)
  );

  // a refused run stays silent on every output strobe
  assert_zero_silent_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    err_zero |-> !rd_en && !res_valid && !done);

  // a division is only ever launched against a non-zero divisor
  assert_div_nonzero_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (div_start && !load_cfg) |-> ideal_q != '0);

endmodule

// File: tb/test_tse_calc.sv
module test_tse_calc;

  localparam int CODE_BITS = 4;
  localparam int TICK_W    = 12;
  localparam int FRAC      = 8;
  localparam int FS_W      = TICK_W + CODE_BITS;
  localparam int RES_W     = FS_W + FRAC + 2;
  localparam int NCODES    = 2 ** CODE_BITS - 1;
  localparam int NVEC      = 7;

  // ideal ticks, full-scale ticks, tick pattern, mid-run start pulse
  localparam int VEC [NVEC][4] = '{
    '{20,   320,   0, 0},
    '{20,   300,   4, 0},
    '{20,   330,   1, 1},
    '{7,    100,   2, 0},
    '{2000, 65535, 3, 0},
    '{1,    0,     1, 0},
    '{4095, 1000,  2, 0}
  };

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    start = 1'b0;
  logic [TICK_W-1:0]       ideal_ticks = '0;
  logic [FS_W-1:0]         fs_ticks = '0;
  logic                    rd_en;
  logic [CODE_BITS-1:0]    rd_addr;
  logic [TICK_W-1:0]       rd_data = '0;
  logic                    res_valid;
  logic [CODE_BITS-1:0]    res_code;
  logic signed [RES_W-1:0] res_dnl, res_inl;
  logic                    done, err_zero;
  logic signed [RES_W-1:0] offset_err, fs_err, gain_err;

  logic [TICK_W-1:0] mem [NCODES];

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  tse_calc #(
    .CODE_BITS (CODE_BITS),
    .TICK_W    (TICK_W),
    .FRAC      (FRAC)
  ) i_tse_calc (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .ideal_ticks (ideal_ticks),
    .fs_ticks    (fs_ticks),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .res_valid   (res_valid),
    .res_code    (res_code),
    .res_dnl     (res_dnl),
    .res_inl     (res_inl),
    .done        (done),
    .err_zero    (err_zero),
    .offset_err  (offset_err),
    .fs_err      (fs_err),
    .gain_err    (gain_err)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tick_of(input int kind, input int i, input int ideal);
    int t;
    case (kind)
      0:       t = ideal;
      1:       t = ideal + (i % 3) - 1;
      2:       t = (i % 2 == 1) ? ideal * 2 : 0;
      3:       t = (i == 0) ? ideal + 5 : ideal - (i % 4);
      default: t = ideal + 1;
    endcase
    if (t > 4095) t = 4095;
    if (t < 0) t = 0;
    return t;
  endfunction

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_vec(input int ideal, input int fs, input int kind, input int inject);
    int exp_dnl [NCODES];
    int exp_inl [NCODES];
    int acc = 0;
    int seen = 0;
    int fin = 0;
    int exp_fs, exp_gain;
    for (int i = 0; i < NCODES; i++) begin
      int p = tick_of(kind, i, ideal);
      mem[i] = TICK_W'(p);
      exp_dnl[i] = ((p - ideal) * 256) / ideal;
      acc += exp_dnl[i];
      exp_inl[i] = acc;
    end
    exp_fs   = ((fs - ideal * 16) * 256) / ideal;
    exp_gain = exp_fs - exp_dnl[0];
    ideal_ticks = TICK_W'(ideal);
    fs_ticks    = FS_W'(fs);
    pulse_start();
    for (int cyc = 0; cyc < 4000 && !fin; cyc++) begin
      @(negedge clk);
      if (inject != 0 && cyc == 60) begin
        start = 1'b1;
        ideal_ticks = 5;
        fs_ticks = 7;
      end else if (inject != 0 && cyc == 61) begin
        start = 1'b0;
      end
      if (res_valid) begin
        if (seen < NCODES) begin
          // R3 ascending code order, R1 DNL, R2 running INL
          check(res_code == CODE_BITS'(seen), "R3 code order", res_code, seen);
          check(res_dnl == RES_W'(exp_dnl[seen]), "R1 dnl", res_dnl, exp_dnl[seen]);
          check(res_inl == RES_W'(exp_inl[seen]), "R2 inl", res_inl, exp_inl[seen]);
        end
        seen++;
      end
      if (done) fin = 1;
    end
    check(fin == 1, "R7 done seen", fin, 1);
    check(seen == NCODES, "R3 result count", seen, NCODES);
    check(offset_err == RES_W'(exp_dnl[0]), "R4 offset", offset_err, exp_dnl[0]);
    check(fs_err == RES_W'(exp_fs), "R5 full-scale", fs_err, exp_fs);
    check(gain_err == RES_W'(exp_gain), "R6 gain", gain_err, exp_gain);
    if (inject != 0) check(fs_err == RES_W'(exp_fs), "R10 start ignored", fs_err, exp_fs);
    // R7: results held after the done pulse
    repeat (3) @(negedge clk);
    check(!done && !res_valid, "R7 single pulse", done, 0);
    check(offset_err == RES_W'(exp_dnl[0]), "R7 held offset", offset_err, exp_dnl[0]);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!res_valid && !done && !err_zero && !rd_en, "R9 reset strobes", {res_valid, done, err_zero, rd_en}, 0);
    check(offset_err == 0 && fs_err == 0 && gain_err == 0, "R9 reset results", offset_err | fs_err | gain_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rd_en && !res_valid && res_dnl == 0, "R9 after release", rd_en, 0);

    // R8 zero ideal count is refused
    ideal_ticks = '0;
    fs_ticks = 100;
    pulse_start();
    begin
      int noise = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (rd_en || res_valid || done) noise++;
      end
      check(noise == 0, "R8 no activity", noise, 0);
    end
    check(err_zero == 1'b1, "R8 flag set", err_zero, 1);

    for (int v = 0; v < NVEC; v++) begin
      run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      if (v == 0) check(err_zero == 1'b0, "R8 flag cleared", err_zero, 0);
    end

    // R1 resolution corner: one extra tick at 20 ticks per LSB gives 12/256
    for (int i = 0; i < NCODES; i++) mem[i] = 21;
    ideal_ticks = 20;
    fs_ticks = 320;
    pulse_start();
    begin
      int got = -1;
      for (int c = 0; c < 200 && got < 0; c++) begin
        @(negedge clk);
        if (res_valid) got = int'(res_dnl);
      end
      check(got == 12, "R1 resolution step", got, 12);
    end
    begin
      int fin = 0;
      for (int c = 0; c < 2000 && !fin; c++) begin
        @(negedge clk);
        if (done) fin = 1;
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule